// File: doc/BRIEF.md
# Word-Aligned Memory Address and Access Unit

This unit sits beside the register file of a 16-register, 32-bit processor and handles every instruction that forms an address. For the indexed forms it adds a sign-extended 16-bit displacement to two register operands in one shared adder. For the register-indirect forms it takes a single register operand as the address. That same sum feeds the data memory port for loads and stores, the destination write for address computation, and the new program counter for the subroutine call.

The memory port always moves a whole 32-bit word. The two low address bits are dropped without any trap. A memory request stays unchanged until the memory answers with a one-cycle ready pulse. Only after that pulse does load data reach the register file and the condition code. Register index 0 reads as zero on every operand path, and a write aimed at it is suppressed. This lets software use index 0 as a null index in an address sum.

Top module: `memAddrUnit`

## Requirements
- R1: After reset, `memReq`, `busy`, `wbEn`, `ccEn`, `jumpEn` and `opDone` are all low.
- R2: `opCode` uses this encoding: 0 indexed load, 1 indexed store, 2 address computation, 3 subroutine call, 4 indirect load, 5 indirect store. For the indexed codes (0 to 3) the address is the sum, modulo 2^32, of `disp` sign-extended from bit 15, the A operand and the B operand. An accepted address computation raises `wbEn` in the next cycle, with `wbData` equal to the full sum and no memory request.
- R3: An operand whose index (`idxA`, `idxB` or `idxD`) is 0 is taken as zero, whatever value is on its register input.
- R4: While `memReq` is high, `memAddr[1:0]` is 0 and `memAddr[31:2]` equals bits 31:2 of the address. The indirect codes (4 and 5) use the A operand alone as the address and ignore `disp` and `regB`.
- R5: An operation is accepted when `opValid` is high and `busy` is low. A memory operation raises `memReq` and `busy` in the next cycle. `memReq`, `memAddr`, `memWe` and `memWdata` then hold unchanged until a cycle in which `memReady` is high, and they drop after that cycle. `opValid` is ignored while `busy` is high.
- R6: For a load (code 0 or 4), in the cycle after `memReady`, `wbEn` is high and `wbData` equals the `memRdata` that was present with `memReady`.
- R7: Codes 0, 4 and 5 raise `ccEn` for one cycle when they complete. `ccFlags` is {N, Z, C, V}, from bit 3 down to bit 0. N is bit 31 of the word, Z is set when the word is zero, and C and V are 0. The word is the loaded data for a load and the stored data for code 5. Code 1 never raises `ccEn`.
- R8: A store (code 1 or 5) drives `memWe` high with `memWdata` equal to the D operand and never raises `wbEn`.
- R9: An accepted subroutine call raises `jumpEn` in the next cycle, with `jumpTarget` equal to the indexed sum. In the same cycle `wbEn` is high with `wbData` equal to `pcIn`.
- R10: When `idxD` is 0, `wbEn` stays low for every code. Condition code and jump outputs are unaffected.
- R11: Codes 6 and 7 are ignored. They produce no request, no pulse and no busy state.
- R12: `opDone` pulses for exactly one cycle when each accepted operation completes. For codes 2 and 3 this is the cycle after acceptance. For memory codes it is the cycle after `memReady`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opValid | input | 1 | Operation offered this cycle |
| opCode | input | 3 | Operation code (see R2) |
| disp | input | 16 | Signed displacement |
| idxA | input | 4 | Register index of first address operand |
| idxB | input | 4 | Register index of second address operand |
| idxD | input | 4 | Register index of data / destination |
| regA | input | 32 | Value read for idxA |
| regB | input | 32 | Value read for idxB |
| regD | input | 32 | Value read for idxD |
| pcIn | input | 32 | Return address for the call |
| memReady | input | 1 | One-cycle memory completion pulse |
| memRdata | input | 32 | Memory read data |
| busy | output | 1 | Memory access outstanding |
| memReq | output | 1 | Memory request |
| memWe | output | 1 | Request is a write |
| memAddr | output | 32 | Word-aligned memory address |
| memWdata | output | 32 | Write data |
| wbEn | output | 1 | Destination register write enable |
| wbData | output | 32 | Destination register write data |
| ccEn | output | 1 | Condition code update strobe |
| ccFlags | output | 4 | {N, Z, C, V} |
| jumpEn | output | 1 | Program counter redirect |
| jumpTarget | output | 32 | New program counter |
| opDone | output | 1 | Operation completion pulse |

## Verification
The assertions assume that `memReady` arrives only while `memReq` is high. They also assume that the memory puts valid read data on `memRdata` in the same cycle as `memReady`. The bench respects both assumptions. It raises `memReady` only after it has seen the request, holds it for exactly one cycle, and drives read data in that same cycle. Within those limits the stimulus draws codes, indices including 0, operand values, displacements and ready delays at random. While the unit is busy it deliberately offers new operations to show that they are ignored.

// File: rtl/memAddrPkg.sv
package memAddrPkg;
  localparam logic [2:0] OP_LOAD   = 3'd0;
  localparam logic [2:0] OP_STORE  = 3'd1;
  localparam logic [2:0] OP_LEA    = 3'd2;
  localparam logic [2:0] OP_JSR    = 3'd3;
  localparam logic [2:0] OP_LOADR  = 3'd4;
  localparam logic [2:0] OP_STORER = 3'd5;

  // strobes from control into datapath
  typedef struct packed {
    logic accept;     // operation taken this cycle
    logic acceptMem;  // taken and needs the memory port
    logic acceptReg;  // taken and completes without memory
    logic complete;   // memory handshake finishes this cycle
  } ctrlStrobeT;

  function automatic logic opIsKnown(input logic [2:0] op);
    return op <= OP_STORER;
  endfunction

  function automatic logic opIsMem(input logic [2:0] op);
    return op == OP_LOAD || op == OP_STORE || op == OP_LOADR || op == OP_STORER;
  endfunction

  function automatic logic opIsIndirect(input logic [2:0] op);
    return op == OP_LOADR || op == OP_STORER;
  endfunction

  function automatic logic opIsLoad(input logic [2:0] op);
    return op == OP_LOAD || op == OP_LOADR;
  endfunction

  function automatic logic opIsStore(input logic [2:0] op);
    return op == OP_STORE || op == OP_STORER;
  endfunction

  // {N, Z, C, V}
  function automatic logic [3:0] flagsOf(input logic [31:0] word);
    return {word[31], word == 32'd0, 2'b00};
  endfunction
endpackage

// File: rtl/memAddrCtrl.sv
module memAddrCtrl
  import memAddrPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       opValid,
  input  logic [2:0] opCode,
  input  logic       memReady,
  output ctrlStrobeT strobes,
  output logic       busy,
  output logic       memReq
);
  typedef enum logic {ST_IDLE, ST_MEM} stateT;
  stateT stateQ, stateD;

  logic takeOp;
  assign takeOp = opValid && (stateQ == ST_IDLE) && opIsKnown(opCode);

  always_comb begin
    strobes.accept    = takeOp;
    strobes.acceptMem = takeOp && opIsMem(opCode);
    strobes.acceptReg = takeOp && !opIsMem(opCode);
    strobes.complete  = (stateQ == ST_MEM) && memReady;
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (strobes.acceptMem) stateD = ST_MEM;
      ST_MEM:  if (memReady) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy   = (stateQ == ST_MEM);
  assign memReq = (stateQ == ST_MEM);
endmodule

// File: rtl/memAddrPath.sv
module memAddrPath
  import memAddrPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DISP_W    = 16,
  parameter int IDX_W     = 4,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobes,
  input  logic [2:0]        opCode,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  idxA,
  input  logic [IDX_W-1:0]  idxB,
  input  logic [IDX_W-1:0]  idxD,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] regD,
  input  logic [DATA_W-1:0] pcIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              storeQ,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData,
  output logic              ccEn,
  output logic [3:0]        ccFlags,
  output logic              jumpEn,
  output logic [DATA_W-1:0] jumpTarget,
  output logic              opDone
);
  localparam int N_OPND = 3;
  localparam int EXT_W  = DATA_W - DISP_W;
  localparam int WORD_W = DATA_W - ALIGN_LSB;

  // operand fetch with index-zero forcing
  logic [IDX_W-1:0]  idxArr  [N_OPND];
  logic [DATA_W-1:0] rawArr  [N_OPND];
  logic [DATA_W-1:0] opndArr [N_OPND];

  assign idxArr[0] = idxA;
  assign idxArr[1] = idxB;
  assign idxArr[2] = idxD;
  assign rawArr[0] = regA;
  assign rawArr[1] = regB;
  assign rawArr[2] = regD;

  for (genvar g = 0; g < N_OPND; g++) begin : gOpnd
    assign opndArr[g] = (idxArr[g] == '0) ? '0 : rawArr[g];
  end

  // single shared three-input adder
  logic              indirect;
  logic [DATA_W-1:0] dispExt, addDisp, addB, addrSum;

  assign indirect = opIsIndirect(opCode);
  assign dispExt  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign addDisp  = indirect ? '0 : dispExt;
  assign addB     = indirect ? '0 : opndArr[1];
  assign addrSum  = opndArr[0] + addB + addDisp;

  // request state captured at acceptance
  logic [WORD_W-1:0] wordAddrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [2:0]        kindQ;
  logic              rdLiveQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordAddrQ <= '0;
      wdataQ    <= '0;
      kindQ     <= '0;
      rdLiveQ   <= 1'b0;
    end else if (strobes.accept) begin
      wordAddrQ <= addrSum[DATA_W-1:ALIGN_LSB];
      wdataQ    <= opndArr[2];
      kindQ     <= opCode;
      rdLiveQ   <= (idxD != '0);
    end
  end

  assign memAddr  = {wordAddrQ, {ALIGN_LSB{1'b0}}};
  assign memWdata = wdataQ;
  assign storeQ   = opIsStore(kindQ);

  // one-cycle result pulses
  logic              wbEnD, ccEnD, jumpEnD, doneD;
  logic [DATA_W-1:0] wbDataD, jumpTgtD;
  logic [3:0]        flagsD;

  always_comb begin
    wbEnD    = 1'b0;
    ccEnD    = 1'b0;
    jumpEnD  = 1'b0;
    doneD    = 1'b0;
    wbDataD  = wbData;
    jumpTgtD = jumpTarget;
    flagsD   = ccFlags;
    if (strobes.acceptReg) begin
      doneD   = 1'b1;
      wbEnD   = (idxD != '0);
      wbDataD = (opCode == OP_JSR) ? pcIn : addrSum;
      if (opCode == OP_JSR) begin
        jumpEnD  = 1'b1;
        jumpTgtD = addrSum;
      end
    end else if (strobes.complete) begin
      doneD = 1'b1;
      if (opIsLoad(kindQ)) begin
        wbEnD   = rdLiveQ;
        wbDataD = memRdata;
        ccEnD   = 1'b1;
        flagsD  = flagsOf(memRdata);
      end else if (kindQ == OP_STORER) begin
        ccEnD  = 1'b1;
        flagsD = flagsOf(wdataQ);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wbEn       <= 1'b0;
      ccEn       <= 1'b0;
      jumpEn     <= 1'b0;
      opDone     <= 1'b0;
      wbData     <= '0;
      jumpTarget <= '0;
      ccFlags    <= '0;
    end else begin
      wbEn       <= wbEnD;
      ccEn       <= ccEnD;
      jumpEn     <= jumpEnD;
      opDone     <= doneD;
      wbData     <= wbDataD;
      jumpTarget <= jumpTgtD;
      ccFlags    <= flagsD;
    end
  end
endmodule

// File: rtl/memAddrUnit.sv
module memAddrUnit
  import memAddrPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int DISP_W    = 16,
  parameter int IDX_W     = 4,
  parameter int ALIGN_LSB = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [DISP_W-1:0] disp,
  input  logic [IDX_W-1:0]  idxA,
  input  logic [IDX_W-1:0]  idxB,
  input  logic [IDX_W-1:0]  idxD,
  input  logic [DATA_W-1:0] regA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] regD,
  input  logic [DATA_W-1:0] pcIn,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              memReq,
  output logic              memWe,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              wbEn,
  output logic [DATA_W-1:0] wbData,
  output logic              ccEn,
  output logic [3:0]        ccFlags,
  output logic              jumpEn,
  output logic [DATA_W-1:0] jumpTarget,
  output logic              opDone
);
  ctrlStrobeT strobes;
  logic       storeQ;

  memAddrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .memReady(memReady), .strobes(strobes), .busy(busy), .memReq(memReq)
  );

  memAddrPath #(
    .DATA_W(DATA_W), .DISP_W(DISP_W), .IDX_W(IDX_W), .ALIGN_LSB(ALIGN_LSB)
  ) u_path (
    .clk(clk), .rstN(rstN), .strobes(strobes), .opCode(opCode), .disp(disp),
    .idxA(idxA), .idxB(idxB), .idxD(idxD), .regA(regA), .regB(regB),
    .regD(regD), .pcIn(pcIn), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .storeQ(storeQ), .wbEn(wbEn), .wbData(wbData),
    .ccEn(ccEn), .ccFlags(ccFlags), .jumpEn(jumpEn),
    .jumpTarget(jumpTarget), .opDone(opDone)
  );

  assign memWe = memReq && storeQ;
endmodule

// File: rtl/memAddrChecker.sv
module memAddrChecker (
  input logic        clk,
  input logic        rstN,
  input logic        memReq,
  input logic        memReady,
  input logic        memWe,
  input logic [31:0] memAddr,
  input logic [31:0] memWdata,
  input logic        busy,
  input logic        ccEn,
  input logic [3:0]  ccFlags,
  input logic        opDone
);
  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> memAddr[1:0] == 2'b00) else $error("addr unaligned"); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata)))
    else $error("request changed"); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> !memReq) else $error("request lingered"); // R5
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady) |=> opDone) else $error("no completion"); // R12
  AST_LOAD_SETS_CC: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memReady && !memWe) |=> ccEn) else $error("load without cc"); // R7
  AST_CC_CARRY_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ccEn |-> ccFlags[1:0] == 2'b00) else $error("C or V set"); // R7
  AST_BUSY_IS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> memReq) else $error("busy without request"); // R5
endmodule

bind memAddrUnit memAddrChecker u_memAddrChecker (
  .clk(clk), .rstN(rstN), .memReq(memReq), .memReady(memReady), .memWe(memWe),
  .memAddr(memAddr), .memWdata(memWdata), .busy(busy), .ccEn(ccEn),
  .ccFlags(ccFlags), .opDone(opDone)
);

// File: tb/memAddrUnit_bench.sv
module memAddrUnit_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [15:0] disp = 16'd0;
  logic [3:0]  idxA = 4'd0, idxB = 4'd0, idxD = 4'd0;
  logic [31:0] regA = 32'd0, regB = 32'd0, regD = 32'd0, pcIn = 32'd0;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = 32'd0;
  logic        busy, memReq, memWe, wbEn, ccEn, jumpEn, opDone;
  logic [31:0] memAddr, memWdata, wbData, jumpTarget;
  logic [3:0]  ccFlags;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;  // 50 MHz

  memAddrUnit u_memAddrUnit (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .disp(disp),
    .idxA(idxA), .idxB(idxB), .idxD(idxD), .regA(regA), .regB(regB),
    .regD(regD), .pcIn(pcIn), .memReady(memReady), .memRdata(memRdata),
    .busy(busy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .wbEn(wbEn), .wbData(wbData), .ccEn(ccEn),
    .ccFlags(ccFlags), .jumpEn(jumpEn), .jumpTarget(jumpTarget), .opDone(opDone)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] opnd(input logic [3:0] idx, input logic [31:0] v);
    return (idx == 4'd0) ? 32'd0 : v;
  endfunction

  function automatic logic [31:0] expSum(input int kind, input logic [15:0] d,
      input logic [3:0] ia, input logic [31:0] a, input logic [3:0] ib, input logic [31:0] b);
    if (kind == 4 || kind == 5) return opnd(ia, a);
    return opnd(ia, a) + opnd(ib, b) + {{16{d[15]}}, d};
  endfunction

  function automatic logic [3:0] expFlags(input logic [31:0] w);
    return {w[31], w == 32'd0, 2'b00};
  endfunction

  task automatic runOp(input int kind, input logic [3:0] ia, input logic [3:0] ib,
      input logic [3:0] id, input logic [31:0] a, input logic [31:0] b, input logic [31:0] d,
      input logic [15:0] dp, input logic [31:0] pc, input logic [31:0] rd, input int delay,
      input bit poke);
    logic [31:0] sum, dataV;
    bit isMem;
    sum   = expSum(kind, dp, ia, a, ib, b);
    dataV = opnd(id, d);
    isMem = (kind == 0 || kind == 1 || kind == 4 || kind == 5);
    opValid = 1'b1; opCode = kind[2:0]; disp = dp; idxA = ia; idxB = ib; idxD = id;
    regA = a; regB = b; regD = d; pcIn = pc;
    @(negedge clk);
    opValid = 1'b0;
    regA = $urandom; regB = $urandom; regD = $urandom; disp = $urandom;
    if (kind > 5) begin
      chk(!memReq && !busy && !wbEn && !opDone && !ccEn && !jumpEn,
          "R11 undefined code ignored", {26'd0, memReq, busy, wbEn, opDone, ccEn, jumpEn}, 32'd0);
    end else if (!isMem) begin
      chk(!memReq, "R2 no memory request", {31'd0, memReq}, 32'd0);
      chk(wbEn == (id != 0), "R10 wbEn vs destination", {31'd0, wbEn}, {31'd0, id != 0});
      chk(opDone, "R12 done after register op", {31'd0, opDone}, 32'd1);
      if (kind == 2) begin
        chk(wbData == sum, "R2 address sum written", wbData, sum);
        chk(!jumpEn, "R2 no jump", {31'd0, jumpEn}, 32'd0);
      end else begin
        chk(jumpEn && jumpTarget == sum, "R9 jump target", jumpTarget, sum);
        chk(wbData == pc, "R9 return address", wbData, pc);
      end
    end else begin
      chk(memReq && busy, "R5 request raised", {30'd0, memReq, busy}, 32'd3);
      chk(memAddr == {sum[31:2], 2'b00}, "R4 aligned address", memAddr, {sum[31:2], 2'b00});
      chk(memWe == (kind == 1 || kind == 5), "R8 write enable", {31'd0, memWe}, {31'd0, kind == 1 || kind == 5});
      if (kind == 1 || kind == 5) chk(memWdata == dataV, "R8 write data", memWdata, dataV);
      for (int i = 0; i < delay; i++) begin
        if (poke && i == 0) begin
          opValid = 1'b1; opCode = 3'd2; idxA = 4'd3; idxD = 4'd5;
        end
        @(negedge clk);
        opValid = 1'b0;
        chk(memReq && memAddr == {sum[31:2], 2'b00}, "R5 request held", memAddr, {sum[31:2], 2'b00});
        chk(!wbEn && !opDone, "R5 new op ignored while busy", {30'd0, wbEn, opDone}, 32'd0);
      end
      memReady = 1'b1; memRdata = rd;
      @(negedge clk);
      memReady = 1'b0; memRdata = $urandom;
      chk(!memReq && !busy, "R5 request dropped", {30'd0, memReq, busy}, 32'd0);
      chk(opDone, "R12 done after ready", {31'd0, opDone}, 32'd1);
      if (kind == 0 || kind == 4) begin
        chk(wbEn == (id != 0), "R10 load write enable", {31'd0, wbEn}, {31'd0, id != 0});
        if (id != 0) chk(wbData == rd, "R6 load data", wbData, rd);
        chk(ccEn && ccFlags == expFlags(rd), "R7 load flags", {27'd0, ccEn, ccFlags}, {27'd1, expFlags(rd)});
      end else begin
        chk(!wbEn, "R8 store no writeback", {31'd0, wbEn}, 32'd0);
        if (kind == 5)
          chk(ccEn && ccFlags == expFlags(dataV), "R7 indirect store flags", {27'd0, ccEn, ccFlags}, {27'd1, expFlags(dataV)});
        else
          chk(!ccEn, "R7 indexed store leaves cc", {31'd0, ccEn}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (2) @(negedge clk);
    chk(!memReq && !busy && !wbEn && !ccEn && !jumpEn && !opDone, "R1 reset state",
        {26'd0, memReq, busy, wbEn, ccEn, jumpEn, opDone}, 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    // directed corners
    runOp(2, 4'd1, 4'd2, 4'd7, 32'h0000_1000, 32'h0000_0010, 0, 16'h8000, 0, 0, 0, 0);      // R2 negative disp
    runOp(2, 4'd1, 4'd2, 4'd7, 32'hFFFF_FFFF, 32'h0000_0003, 0, 16'h0001, 0, 0, 0, 0);      // R2 wrap
    runOp(2, 4'd0, 4'd0, 4'd7, 32'hDEAD_BEEF, 32'h1234_5678, 0, 16'h0040, 0, 0, 0, 0);      // R3 null indices
    runOp(3, 4'd4, 4'd0, 4'd15, 32'h0000_2000, 32'h5, 0, 16'h0006, 32'h0000_0102, 0, 0, 0); // R9
    runOp(3, 4'd4, 4'd5, 4'd0, 32'h0000_2000, 32'h5, 0, 16'h0006, 32'h0000_0102, 0, 0, 0);  // R10 call rd=0
    runOp(0, 4'd1, 4'd2, 4'd3, 32'h0000_1003, 32'h1, 0, 16'h0002, 0, 32'h0, 2, 1);          // R4 R6 Z flag, poke
    runOp(4, 4'd6, 4'd2, 4'd3, 32'h0000_0ABF, 32'h77, 0, 16'h1234, 0, 32'h8000_0001, 1, 1); // R4 indirect, N flag
    runOp(0, 4'd1, 4'd2, 4'd0, 32'h40, 32'h0, 0, 16'h0, 0, 32'h5555_AAAA, 0, 0);            // R10 load rd=0
    runOp(1, 4'd1, 4'd2, 4'd9, 32'h100, 32'h7, 32'hCAFE_F00D, 16'hFFFE, 0, 0, 3, 1);        // R8 store
    runOp(5, 4'd1, 4'd2, 4'd0, 32'h203, 32'h7, 32'hCAFE_F00D, 16'h0, 0, 0, 1, 0);           // R3 R7 store zero data
    runOp(6, 4'd1, 4'd2, 4'd3, 32'h1, 32'h2, 32'h3, 16'h4, 0, 0, 0, 0);                     // R11
    runOp(7, 4'd1, 4'd2, 4'd3, 32'h1, 32'h2, 32'h3, 16'h4, 0, 0, 0, 0);                     // R11
    // random mix
    for (int n = 0; n < 300; n++) begin
      runOp(int'($urandom % 8), 4'($urandom), 4'($urandom), 4'($urandom), $urandom, $urandom,
            $urandom, 16'($urandom), $urandom, ($urandom % 4 == 0) ? 32'd0 : $urandom,
            int'($urandom % 4), 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule